// File: doc/BRIEF.md
# Sequential Radix-4 Signed-Digit Multiplier

This block multiplies two N-digit numbers held in quaternary signed-digit form and returns their product in the same form. Every digit takes a value from -3 to +3 and is carried as a 3-bit two's complement field. A shift-and-add loop computes the product. Each iteration multiplies the whole multiplicand by one digit of the multiplier, starting with the least significant digit. It moves that partial product up to the digit position of the multiplier digit and adds it into an accumulator. Both the partial product generator and the accumulator adder are carry-free signed-digit adders, so the time for one iteration does not depend on N.

A caller applies the operands and pulses the start input while the block is idle. The block then stays busy for N cycles and raises done for one cycle. From that cycle on, the product output holds the result until the next start. The product has 2N digits of value plus one guard digit on top. The carry-free accumulator is allowed to move a unit of value into that guard digit even when the final value would fit in 2N digits.

Top module: `qsd_iter_mul`

## Requirements
- R1: Each digit is a 3-bit two's complement field in the range -3..+3. Digit k of an operand sits at bits [3k+2:3k]. The product has 2N+1 digits, digit k at bits [3k+2:3k], and its value is the sum of digit_k * 4^k.
- R2: When start_i is high while busy_o is low, the rising edge latches a_i and b_i, clears the accumulator, and raises busy_o.
- R3: busy_o stays high for exactly N cycles after the start edge. done_o is high for exactly the one cycle that follows and is then low again.
- R4: When done_o is high, the product value equals value(a_i) * value(b_i) as latched at the start edge. This holds for all legal operands, including the extreme ones.
- R5: A start_i pulse while busy_o is high is ignored, so the running product is unchanged.
- R6: Outside a run, the product output keeps its value until the next accepted start.
- R7: Every product digit is in -3..+3 (the code 3'b100 never appears). The accumulator adder never carries out past the guard digit, and the partial product generator never carries out past digit N.
- R8: While reset is asserted and after it is released, busy_o and done_o are low and the product is all zero.
- R9: Changes on a_i and b_i during a run have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, accepted only when idle |
| a_i | input | 3*N | Multiplicand digits |
| b_i | input | 3*N | Multiplier digits |
| busy_o | output | 1 | Iteration in progress |
| done_o | output | 1 | One-cycle completion pulse |
| product_o | output | 3*(2N+1) | Product digits, least significant digit first |

## Verification
Random operands with every digit drawn from -3..+3 exercise mixed-sign digit products and redundant accumulator states; a wrong carry or split rule shows up there as a value error. Directed cases cover the extremes: all +3 times all +3, mixed extremes, zero, and -1 times -1. These reach the largest single-digit products (±9) and the largest accumulator magnitude. A single-digit pair checks the digit positions bit for bit, which separates a misaligned partial product from an arithmetic fault. Runs that pulse start and change the operands while busy, then hold idle with changing inputs, separate latching and hold behaviour from the arithmetic.

// File: rtl/qsd_pkg.sv
package qsd_pkg;
  localparam int unsigned DIGIT_W = 3;
  typedef logic signed [DIGIT_W-1:0] qdig_t;
  typedef logic signed [1:0]         qcar_t;
  localparam qcar_t CAR_POS  = 2'sb01;
  localparam qcar_t CAR_NEG  = 2'sb11;
  localparam qcar_t CAR_ZERO = 2'sb00;
endpackage

// File: rtl/qsd_adder.sv
module qsd_adder
  import qsd_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  logic [DIGIT_W*W-1:0] x_i,
  input  logic [DIGIT_W*W-1:0] y_i,
  output logic [DIGIT_W*W-1:0] sum_o,
  output logic [1:0]           carry_o
);
  logic [2*W-1:0] car_v;

  for (genvar g = 0; g < W; g++) begin : g_dig
    qdig_t              xd, yd;
    logic signed [3:0]  raw, rem;
    qcar_t              c, cin;

    assign xd  = x_i[DIGIT_W*g +: DIGIT_W];
    assign yd  = y_i[DIGIT_W*g +: DIGIT_W];
    assign raw = {xd[2], xd} + {yd[2], yd};

    // step 1: keep |rem| <= 2, |c| <= 1
    always_comb begin
      if (raw > 4'sd2)       c = CAR_POS;
      else if (raw < -4'sd2) c = CAR_NEG;
      else                   c = CAR_ZERO;
    end
    assign rem = raw - {c, 2'b00};
    assign car_v[2*g +: 2] = c;

    if (g == 0) begin : g_lsd
      assign cin = CAR_ZERO;
    end else begin : g_up
      assign cin = car_v[2*(g-1) +: 2];
    end

    // step 2: absorb lower carry, no further carry
    assign sum_o[DIGIT_W*g +: DIGIT_W] = rem[2:0] + {cin[1], cin};
  end

  assign carry_o = car_v[2*W-1 -: 2];
endmodule

// File: rtl/qsd_digit_mul.sv
module qsd_digit_mul
  import qsd_pkg::*;
(
  input  logic [DIGIT_W-1:0] a_i,
  input  logic [DIGIT_W-1:0] b_i,
  output logic [DIGIT_W-1:0] m_o,
  output logic [DIGIT_W-1:0] c_o
);
  logic signed [5:0] prod, biased, hi, lo;

  assign prod   = {{3{a_i[2]}}, a_i} * {{3{b_i[2]}}, b_i};
  assign biased = prod + 6'sd2;
  // hi in -2..2, lo in -2..2, prod = 4*hi + lo
  assign hi     = biased >>> 2;
  assign lo     = prod - (hi <<< 2);
  assign m_o    = lo[2:0];
  assign c_o    = hi[2:0];
endmodule

// File: rtl/qsd_pp_gen.sv
module qsd_pp_gen
  import qsd_pkg::*;
#(
  parameter int unsigned N = 4
) (
  input  logic [DIGIT_W*N-1:0]     a_i,
  input  logic [DIGIT_W-1:0]       d_i,
  output logic [DIGIT_W*(N+1)-1:0] pp_o,
  output logic [1:0]               carry_o
);
  localparam int unsigned PPD = N + 1;

  logic [DIGIT_W*PPD-1:0] m_vec, c_vec;

  assign m_vec[DIGIT_W*N +: DIGIT_W] = '0;
  assign c_vec[0 +: DIGIT_W]         = '0;

  for (genvar k = 0; k < N; k++) begin : g_mul
    qsd_digit_mul u_dm (
      .a_i (a_i[DIGIT_W*k +: DIGIT_W]),
      .b_i (d_i),
      .m_o (m_vec[DIGIT_W*k +: DIGIT_W]),
      .c_o (c_vec[DIGIT_W*(k+1) +: DIGIT_W])
    );
  end

  qsd_adder #(.W(PPD)) u_gather (
    .x_i     (m_vec),
    .y_i     (c_vec),
    .sum_o   (pp_o),
    .carry_o (carry_o)
  );
endmodule

// File: rtl/qsd_iter_mul.sv
module qsd_iter_mul
  import qsd_pkg::*;
#(
  parameter int unsigned N = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         start_i,
  input  logic [DIGIT_W*N-1:0]         a_i,
  input  logic [DIGIT_W*N-1:0]         b_i,
  output logic                         busy_o,
  output logic                         done_o,
  output logic [DIGIT_W*(2*N+1)-1:0]   product_o
);
  localparam int unsigned PW  = 2*N + 1;
  localparam int unsigned PPD = N + 1;
  localparam int unsigned CW  = $clog2(N + 1);

  logic [DIGIT_W*N-1:0]   a_q, b_q;
  logic [DIGIT_W*PW-1:0]  acc_q, acc_nxt, pp_ext, pp_al;
  logic [DIGIT_W*PPD-1:0] pp;
  logic [CW-1:0]          cnt_q;
  logic                   busy_q, done_q;
  logic [1:0]             acc_carry, pp_carry;

  qsd_pp_gen #(.N(N)) u_ppg (
    .a_i     (a_q),
    .d_i     (b_q[DIGIT_W-1:0]),
    .pp_o    (pp),
    .carry_o (pp_carry)
  );

  assign pp_ext = {{(DIGIT_W*(PW-PPD)){1'b0}}, pp};
  assign pp_al  = pp_ext << (DIGIT_W*cnt_q);

  qsd_adder #(.W(PW)) u_acc_add (
    .x_i     (acc_q),
    .y_i     (pp_al),
    .sum_o   (acc_nxt),
    .carry_o (acc_carry)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q    <= '0;
      b_q    <= '0;
      acc_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        a_q    <= a_i;
        b_q    <= b_i;
        acc_q  <= '0;
        cnt_q  <= '0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        acc_q <= acc_nxt;
        b_q   <= b_q >> DIGIT_W;
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CW'(N-1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign product_o = acc_q;
endmodule

// File: rtl/qsd_iter_mul_chk.sv
module qsd_iter_mul_chk #(
  parameter int unsigned N = 4
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    start_i,
  input logic                    busy_o,
  input logic                    done_o,
  input logic [3*(2*N+1)-1:0]    product_o,
  input logic [1:0]              acc_carry,
  input logic [1:0]              pp_carry
);
  localparam int unsigned PW = 2*N + 1;
  localparam int unsigned RW = $clog2(N + 2);

  logic [RW-1:0] run_cnt;
  logic          bad_digit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 run_cnt <= '0;
    else if (start_i && !busy_o) run_cnt <= '0;
    else if (busy_o)             run_cnt <= run_cnt + 1'b1;
  end

  always_comb begin
    bad_digit = 1'b0;
    for (int k = 0; k < PW; k++)
      if (product_o[3*k +: 3] == 3'b100) bad_digit = 1'b1;
  end

  p_start_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);
  p_done_len_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (run_cnt == RW'(N)));
  p_done_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_after_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  p_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));
  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(product_o));
  p_digit_legal_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bad_digit);
  p_no_overflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (acc_carry == 2'b00));
  p_pp_no_carry_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (pp_carry == 2'b00));

  always_comb begin
    if (!rst_ni) begin
      a_reset_idle_r8: assert (!busy_o && !done_o);
    end
  end
endmodule

bind qsd_iter_mul qsd_iter_mul_chk #(.N(N)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .product_o (product_o),
  .acc_carry (acc_carry),
  .pp_carry  (pp_carry)
);

// File: tb/tb_qsd_iter_mul.sv
`timescale 1ns/1ps
module tb_qsd_iter_mul;
  localparam int N  = 4;
  localparam int PW = 2*N + 1;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              start_i = 1'b0;
  logic [3*N-1:0]    a_i = '0, b_i = '0;
  logic              busy_o, done_o;
  logic [3*PW-1:0]   product_o;

  int errors = 0;
  int checks = 0;

  qsd_iter_mul #(.N(N)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .a_i(a_i), .b_i(b_i), .busy_o(busy_o), .done_o(done_o),
    .product_o(product_o)
  );

  always #10 clk_i = ~clk_i;

  function automatic longint val_op(input logic [3*N-1:0] v);
    longint s = 0, w = 1;
    for (int k = 0; k < N; k++) begin
      s += longint'(signed'(v[3*k +: 3])) * w;
      w *= 4;
    end
    return s;
  endfunction

  function automatic longint val_prod(input logic [3*PW-1:0] v);
    longint s = 0, w = 1;
    for (int k = 0; k < PW; k++) begin
      s += longint'(signed'(v[3*k +: 3])) * w;
      w *= 4;
    end
    return s;
  endfunction

  function automatic bit legal_prod(input logic [3*PW-1:0] v);
    for (int k = 0; k < PW; k++)
      if (v[3*k +: 3] == 3'b100) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic [3*N-1:0] rnd_op();
    logic [3*N-1:0] v;
    for (int k = 0; k < N; k++) begin
      int d = int'($urandom_range(0, 6)) - 3;
      v[3*k +: 3] = d[2:0];
    end
    return v;
  endfunction

  function automatic logic [3*N-1:0] fill_op(input int d);
    logic [3*N-1:0] v;
    for (int k = 0; k < N; k++) v[3*k +: 3] = d[2:0];
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [3*N-1:0] a, input logic [3*N-1:0] b, input bit disturb);
    longint exp = val_op(a) * val_op(b);
    int busy_cnt = 0;
    logic [3*PW-1:0] held;
    @(negedge clk_i);
    a_i = a; b_i = b; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R2 busy after start", longint'(busy_o), 1);
    for (int i = 0; i < 60 && !done_o; i++) begin
      if (busy_o) busy_cnt++;
      if (disturb && i == 1) begin
        a_i = rnd_op(); b_i = rnd_op(); start_i = 1'b1;  // R5, R9
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk_i);
    end
    start_i = 1'b0;
    chk(done_o == 1'b1, "R3 done seen", longint'(done_o), 1);
    chk(busy_cnt == N, "R3 busy length", longint'(busy_cnt), longint'(N));
    if (disturb)
      chk(val_prod(product_o) == exp, "R5 R9 product after disturbance", val_prod(product_o), exp);
    else
      chk(val_prod(product_o) == exp, "R4 product value", val_prod(product_o), exp);
    chk(legal_prod(product_o), "R7 digit range", longint'(legal_prod(product_o)), 1);
    held = product_o;
    @(negedge clk_i);
    chk(done_o == 1'b0, "R3 done one cycle", longint'(done_o), 0);
    a_i = rnd_op(); b_i = rnd_op();
    repeat (3) @(negedge clk_i);
    chk(product_o == held, "R6 product held", val_prod(product_o), val_prod(held));
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !done_o && product_o == '0, "R8 in reset", val_prod(product_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!busy_o && !done_o && product_o == '0, "R8 after reset", val_prod(product_o), 0);

    // R1: value 1 times 4^3 lands exactly on digit 3
    run_op(12'(1), 12'(1) << 9, 1'b0);
    chk(product_o == (27'(1) << 9), "R1 digit position", val_prod(product_o), 64);

    run_op(fill_op(3), fill_op(3), 1'b0);     // R4 max * max
    run_op(fill_op(-3), fill_op(3), 1'b0);    // R4 min * max
    run_op(fill_op(-3), fill_op(-3), 1'b0);   // R4 min * min
    run_op('0, fill_op(3), 1'b0);             // R4 zero
    run_op(fill_op(-1), fill_op(-1), 1'b0);   // R4 small negative
    run_op(fill_op(3), fill_op(-2), 1'b1);    // R5 R9 directed

    for (int t = 0; t < 60; t++)
      run_op(rnd_op(), rnd_op(), (t % 4) == 3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule